// File: doc/BRIEF.md
# SIMD Array Lane Datapath

This block is a single lane of a lock-step SIMD processing array. A central sequencer broadcasts one decoded control word per clock to every lane, together with a signed byte on a shared input bus. Each lane holds its own byte-addressable scratch memory, a bank of 16-bit working registers, a 12-bit address register with its own adder, a pipelined 9-by-16-bit multiplier that feeds a 32-bit accumulator, and a transfer register that is linked to the lanes on either side.

Every lane runs the same instruction, but each one has its own data and its own address. An instruction may be made conditional on the lane's zero and negative flags. A lane that fails its condition does nothing for that cycle. A global ignore input turns the current instruction into a no-op in every lane. Multiply-accumulate is pipelined by one stage. In a single instruction the lane multiplies the bus byte by a memory word, adds the product held from the previous instruction to the running sum, and steps the address register.

Top module: `simd_lane`

## Requirements
- R1: After a synchronous reset the accumulator and the transfer register read 0, the zero flag reads 1, and the negative flag and the misalignment flag read 0.
- R2: Opcode 9 (bus load) writes the bus byte, sign-extended to 16 bits, into the selected register (any of 32). Opcode 14 copies the transfer register into the selected register. Opcode 11 copies the selected register into the transfer register, and this is how register contents are observed.
- R3: Memory is 4096 bytes and stores 16-bit words little-endian, with the low byte at the even address. Opcode 5 stores a word and opcode 7 loads a word. Opcode 6 stores the low byte of the register at any address and leaves the other byte of that word untouched. Opcode 8 loads a byte, zero-extended.
- R4: Opcode 2 (MAC) captures the product of the signed bus byte and the signed memory word at the address register, adds the previously captured product to the accumulator, and adds the offset field to the address register. Opcode 3 adds the held product and then clears it. Opcode 1 clears both the accumulator and the held product. Opcode 10 adds the sign-extended selected register to the accumulator.
- R5: The zero flag equals (accumulator == 0) and the negative flag equals bit 31 of the accumulator. Both flags change only on executed opcodes 1, 2, 3 and 10.
- R6: The condition field works as follows: 0 always executes, 1 executes when the zero flag is set, 2 executes when the negative flag is set, and 3 executes when the zero flag is clear. A skipped instruction changes no state.
- R7: While the ignore input is high, the instruction changes no register, no memory byte, no flag and no output.
- R8: Opcode 12 loads the transfer register from the right-hand neighbour input. Opcode 13 loads it from the left-hand neighbour input.
- R9: An executed word access (opcode 2, 5 or 7) at an odd address sets the misalignment output for the next cycle only. At an odd address a word store writes nothing and a word load returns 0.
- R10: Opcode 4 loads the offset field into the address register. The step made by opcode 2 wraps modulo 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ignore_i | input | 1 | Global no-op request from the sequencer |
| op_i | input | 4 | Opcode of the broadcast instruction |
| cond_i | input | 2 | Execution condition |
| reg_sel_i | input | 5 | Register-file index |
| offset_i | input | 12 | Address value or address step |
| bus_i | input | 8 | Broadcast signed byte |
| from_left_i | input | 16 | Transfer register of the left neighbour |
| from_right_i | input | 16 | Transfer register of the right neighbour |
| nbr_o | output | 16 | Transfer register, seen by the neighbours |
| acc_o | output | 32 | Accumulator |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| misalign_o | output | 1 | Odd-address word access on the previous instruction |

## Verification
The assertions take the control inputs as valid for every cycle after reset. This means the opcode is one of the 15 defined values, the ignore input is a clean level, and the neighbour inputs are known whenever a shift executes. The properties on the multiply pipeline also assume that no memory byte read by a MAC is uninitialised. The stimulus keeps within these limits: it drives every input from reset onward, only ever issues defined opcodes, and writes every memory word before a MAC or load touches it, including the wrap-around location near the top of the address space.

// File: rtl/lane_pkg.sv
`timescale 1ns/1ps
package lane_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int ACC_W  = 32;
  localparam int MUL_A_W = BYTE_W + 1;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_CLR    = 4'd1,
    OP_MAC    = 4'd2,
    OP_DRAIN  = 4'd3,
    OP_SETA   = 4'd4,
    OP_ST16   = 4'd5,
    OP_ST8    = 4'd6,
    OP_LD16   = 4'd7,
    OP_LD8    = 4'd8,
    OP_LDBUS  = 4'd9,
    OP_ACCADD = 4'd10,
    OP_NBRLD  = 4'd11,
    OP_SHL    = 4'd12,
    OP_SHR    = 4'd13,
    OP_NBRST  = 4'd14
  } op_e;

  typedef enum logic [1:0] {
    C_ALWAYS  = 2'd0,
    C_ZERO    = 2'd1,
    C_NEG     = 2'd2,
    C_NONZERO = 2'd3
  } cond_e;
endpackage

// File: rtl/lane_regfile.sv
`timescale 1ns/1ps
module lane_regfile #(
  parameter int W = 16,
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] idx,
  input  logic [W-1:0]         wdata,
  output logic [W-1:0]         rdata
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (we) regs[idx] <= wdata;
  end

  assign rdata = regs[idx];
endmodule

// File: rtl/lane_mem.sv
`timescale 1ns/1ps
module lane_mem #(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                we,
  input  logic                wide,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*BYTE_W-1:0] wdata,
  output logic [2*BYTE_W-1:0] rdata,
  output logic                odd_wide
);
  localparam int HALF = 1 << (ADDR_W - 1);

  logic [BYTE_W-1:0] bank_even [HALF];
  logic [BYTE_W-1:0] bank_odd  [HALF];
  logic [ADDR_W-2:0] row;
  logic              we_even, we_odd;
  logic [BYTE_W-1:0] rd_even, rd_odd;

  assign row      = addr[ADDR_W-1:1];
  assign odd_wide = wide && addr[0];
  assign we_even  = we && (wide ? !addr[0] : !addr[0]);
  assign we_odd   = we && (wide ? !addr[0] : addr[0]);

  always_ff @(posedge clk) begin
    if (we_even) bank_even[row] <= wdata[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (we_odd) bank_odd[row] <= wide ? wdata[2*BYTE_W-1:BYTE_W] : wdata[BYTE_W-1:0];
  end

  assign rd_even = bank_even[row];
  assign rd_odd  = bank_odd[row];

  always_comb begin
    if (wide)         rdata = odd_wide ? '0 : {rd_odd, rd_even};
    else if (addr[0]) rdata = {{BYTE_W{1'b0}}, rd_odd};
    else              rdata = {{BYTE_W{1'b0}}, rd_even};
  end
endmodule

// File: rtl/lane_mac.sv
`timescale 1ns/1ps
module lane_mac #(
  parameter int A_W   = 9,
  parameter int B_W   = 16,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    mac_en,
  input  logic                    drain_en,
  input  logic                    add_en,
  input  logic signed [A_W-1:0]   a_i,
  input  logic signed [B_W-1:0]   b_i,
  input  logic [ACC_W-1:0]        addend_i,
  output logic [ACC_W-1:0]        acc_o,
  output logic                    zero_o,
  output logic                    neg_o
);
  localparam int P_W = A_W + B_W;

  logic signed [P_W-1:0] prod_q, prod_now;
  logic [ACC_W-1:0]      prod_ext, incr, acc_nx;

  assign prod_now = a_i * b_i;
  assign prod_ext = {{(ACC_W-P_W){prod_q[P_W-1]}}, prod_q};
  assign incr     = add_en ? addend_i : prod_ext;
  assign acc_nx   = acc_o + incr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_o  <= '0;
      prod_q <= '0;
      zero_o <= 1'b1;
      neg_o  <= 1'b0;
    end else if (mac_en || drain_en || add_en) begin
      acc_o  <= acc_nx;
      zero_o <= (acc_nx == '0);
      neg_o  <= acc_nx[ACC_W-1];
      if (mac_en)        prod_q <= prod_now;
      else if (drain_en) prod_q <= '0;
    end
  end

  a_r5_flags_follow_acc: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (zero_o == (acc_o == '0)) && (neg_o == acc_o[ACC_W-1]));

  a_r4_mac_adds_held_product: assert property (@(posedge clk) disable iff (rst)
    (mac_en && !clr) |=> acc_o == $past(acc_o) + $past(prod_ext));

  a_r4_drain_empties_product: assert property (@(posedge clk) disable iff (rst)
    (drain_en && !clr && !mac_en) |=> prod_q == '0);
endmodule

// File: rtl/simd_lane.sv
`timescale 1ns/1ps
module simd_lane
  import lane_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int REG_N  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ignore_i,
  input  logic [3:0]         op_i,
  input  logic [1:0]         cond_i,
  input  logic [4:0]         reg_sel_i,
  input  logic [ADDR_W-1:0]  offset_i,
  input  logic [7:0]         bus_i,
  input  logic [15:0]        from_left_i,
  input  logic [15:0]        from_right_i,
  output logic [15:0]        nbr_o,
  output logic [31:0]        acc_o,
  output logic               zero_o,
  output logic               neg_o,
  output logic               misalign_o
);
  localparam int SEL_W = $clog2(REG_N);

  op_e                op;
  cond_e              cond;
  logic               cond_ok, exec, wide;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  rf_rdata, rf_wdata, mem_rdata;
  logic               rf_we, mem_we, odd_wide;
  logic [SEL_W-1:0]   sel;
  logic [ACC_W-1:0]   addend;
  logic signed [MUL_A_W-1:0] bus_sx;

  assign op     = op_e'(op_i);
  assign cond   = cond_e'(cond_i);
  assign sel    = reg_sel_i[SEL_W-1:0];
  assign bus_sx = {bus_i[BYTE_W-1], bus_i};
  assign addend = {{(ACC_W-DATA_W){rf_rdata[DATA_W-1]}}, rf_rdata};

  always_comb begin
    unique case (cond)
      C_ALWAYS:  cond_ok = 1'b1;
      C_ZERO:    cond_ok = zero_o;
      C_NEG:     cond_ok = neg_o;
      C_NONZERO: cond_ok = !zero_o;
      default:   cond_ok = 1'b0;
    endcase
  end

  assign exec   = !ignore_i && cond_ok;
  assign wide   = (op == OP_ST16) || (op == OP_LD16) || (op == OP_MAC);
  assign mem_we = exec && ((op == OP_ST16) || (op == OP_ST8));
  assign rf_we  = exec && ((op == OP_LD16) || (op == OP_LD8) ||
                           (op == OP_LDBUS) || (op == OP_NBRST));

  always_comb begin
    case (op)
      OP_LDBUS: rf_wdata = {{(DATA_W-BYTE_W){bus_i[BYTE_W-1]}}, bus_i};
      OP_NBRST: rf_wdata = nbr_o;
      default:  rf_wdata = mem_rdata;
    endcase
  end

  lane_regfile #(.W(DATA_W), .N(REG_N)) u_rf (
    .clk(clk), .we(rf_we), .idx(sel), .wdata(rf_wdata), .rdata(rf_rdata)
  );

  lane_mem #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .wide(wide), .addr(addr_q),
    .wdata(rf_rdata), .rdata(mem_rdata), .odd_wide(odd_wide)
  );

  lane_mac #(.A_W(MUL_A_W), .B_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst(rst),
    .clr(exec && op == OP_CLR),
    .mac_en(exec && op == OP_MAC),
    .drain_en(exec && op == OP_DRAIN),
    .add_en(exec && op == OP_ACCADD),
    .a_i(bus_sx), .b_i(mem_rdata), .addend_i(addend),
    .acc_o(acc_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      nbr_o      <= '0;
      misalign_o <= 1'b0;
    end else begin
      misalign_o <= exec && odd_wide;
      if (exec) begin
        case (op)
          OP_SETA:  addr_q <= offset_i;
          OP_MAC:   addr_q <= addr_q + offset_i;
          OP_NBRLD: nbr_o  <= rf_rdata;
          OP_SHL:   nbr_o  <= from_right_i;
          OP_SHR:   nbr_o  <= from_left_i;
          default:  ;
        endcase
      end
    end
  end

  a_r7_ignore_freezes: assert property (@(posedge clk) disable iff (rst)
    ignore_i |=> $stable(acc_o) && $stable(nbr_o) && $stable(zero_o) &&
                 $stable(neg_o) && !misalign_o);

  a_r6_skip_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    !exec |=> $stable(zero_o) && $stable(neg_o) && $stable(acc_o));

  a_r8_shift_from_right: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_SHL) |=> nbr_o == $past(from_right_i));

  a_r8_shift_from_left: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_SHR) |=> nbr_o == $past(from_left_i));

  a_r9_odd_store_flagged: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_ST16 && addr_q[0]) |=> misalign_o);

  a_r10_seta_loads: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_SETA) |=> addr_q == $past(offset_i));
endmodule

// File: tb/simd_lane_tb.sv
`timescale 1ns/1ps
module simd_lane_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ignore_i = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [1:0]  cond_i = 2'd0;
  logic [4:0]  reg_sel_i = 5'd0;
  logic [11:0] offset_i = 12'd0;
  logic [7:0]  bus_i = 8'd0;
  logic [15:0] from_left_i = 16'd0;
  logic [15:0] from_right_i = 16'd0;
  logic [15:0] nbr_o;
  logic [31:0] acc_o;
  logic        zero_o, neg_o, misalign_o;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  simd_lane u_dut (
    .clk(clk), .rst(rst), .ignore_i(ignore_i), .op_i(op_i), .cond_i(cond_i),
    .reg_sel_i(reg_sel_i), .offset_i(offset_i), .bus_i(bus_i),
    .from_left_i(from_left_i), .from_right_i(from_right_i),
    .nbr_o(nbr_o), .acc_o(acc_o), .zero_o(zero_o), .neg_o(neg_o),
    .misalign_o(misalign_o)
  );

  localparam logic [3:0] CLR=1, MAC=2, DRAIN=3, SETA=4, ST16=5, ST8=6, LD16=7,
                         LD8=8, LDBUS=9, ACCADD=10, NBRLD=11, SHL=12, SHR=13, NBRST=14;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [4:0] rs = 0,
                       input logic [11:0] off = 0, input logic [7:0] bus = 0,
                       input logic [1:0] cond = 0, input logic ign = 0);
    op_i = op; reg_sel_i = rs; offset_i = off; bus_i = bus; cond_i = cond; ignore_i = ign;
    @(negedge clk);
    op_i = 4'd0; ignore_i = 1'b0; cond_i = 2'd0;
  endtask

  task automatic load_reg(input logic [4:0] rs, input logic [15:0] v);
    from_right_i = v;
    issue(SHL);
    issue(NBRST, rs);
  endtask

  task automatic read_reg(input logic [4:0] rs, output logic [15:0] v);
    issue(NBRLD, rs);
    v = nbr_o;
  endtask

  task automatic t_reset();
    check("R1 acc", acc_o, 0);
    check("R1 nbr", nbr_o, 0);
    check("R1 flags z,n,mis", {zero_o, neg_o, misalign_o}, 3'b100);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    issue(LDBUS, 3, 0, 8'h85); read_reg(3, v); check("R2 sign-extended bus byte", v, 16'hFF85);
    issue(LDBUS, 31, 0, 8'h22); read_reg(31, v); check("R2 top register", v, 16'h0022);
    load_reg(0, 16'hBEEF); read_reg(0, v); check("R2 transfer to register", v, 16'hBEEF);
  endtask

  task automatic t_mem();
    logic [15:0] v;
    load_reg(1, 16'h1234);
    issue(SETA, 0, 12'h040); issue(ST16, 1); issue(LD16, 2);
    read_reg(2, v); check("R3 word round trip", v, 16'h1234);
    issue(LD8, 2); read_reg(2, v); check("R3 low byte at even address", v, 16'h0034);
    issue(SETA, 0, 12'h041); issue(LD8, 2); read_reg(2, v);
    check("R3 high byte at odd address", v, 16'h0012);
    load_reg(4, 16'h00AB); issue(ST8, 4);
    issue(SETA, 0, 12'h040); issue(LD16, 2); read_reg(2, v);
    check("R3 byte store keeps other byte", v, 16'hAB34);
  endtask

  task automatic t_mac();
    load_reg(1, 16'h0003); issue(SETA, 0, 12'h010); issue(ST16, 1);
    load_reg(1, 16'hFFFE); issue(SETA, 0, 12'h012); issue(ST16, 1);
    issue(SETA, 0, 12'h010); issue(CLR);
    check("R4 clear", acc_o, 0);
    issue(MAC, 0, 12'd2, 8'd5);
    check("R4 first MAC adds empty product", acc_o, 0);
    issue(MAC, 0, 12'd2, 8'hFC);
    check("R4 second MAC adds 5*3", acc_o, 15);
    issue(DRAIN);
    check("R4 drain adds -4*-2", acc_o, 23);
    issue(DRAIN);
    check("R4 second drain adds nothing", acc_o, 23);
    issue(CLR); issue(SETA, 0, 12'h012); issue(MAC, 0, 0, 8'h7F); issue(DRAIN);
    check("R4 negative product", acc_o, 32'hFFFFFF02);
    check("R5 negative flag", {zero_o, neg_o}, 2'b01);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    issue(SETA, 0, 12'h002); issue(ST8, 0);
    load_reg(1, 16'h0101); issue(SETA, 0, 12'hFFE); issue(ST16, 1);
    issue(CLR); issue(MAC, 0, 12'd4, 8'd0);
    load_reg(6, 16'h0077); issue(ST8, 6);
    issue(SETA, 0, 12'h002); issue(LD8, 7); read_reg(7, v);
    check("R10 address step wraps to 0x002", v, 16'h0077);
    issue(DRAIN); check("R10 MAC at top word, zero bus", acc_o, 0);
  endtask

  task automatic t_cond();
    logic [15:0] v;
    issue(CLR); check("R5 zero flag after clear", {zero_o, neg_o}, 2'b10);
    load_reg(5, 16'hFFFF); issue(ACCADD, 5);
    check("R4 register add", acc_o, 32'hFFFFFFFF);
    check("R5 flags on -1", {zero_o, neg_o}, 2'b01);
    issue(LDBUS, 8, 0, 8'h11);
    issue(LDBUS, 8, 0, 8'h07, 2'd1); read_reg(8, v);
    check("R6 zero condition skipped", v, 16'h0011);
    issue(ACCADD, 5, 0, 0, 2'd1);
    check("R6 skipped add leaves acc", acc_o, 32'hFFFFFFFF);
    check("R5 skipped add leaves flags", {zero_o, neg_o}, 2'b01);
    issue(LDBUS, 8, 0, 8'h07, 2'd2); read_reg(8, v);
    check("R6 negative condition runs", v, 16'h0007);
    load_reg(9, 16'h0001); issue(ACCADD, 9, 0, 0, 2'd3);
    check("R6 nonzero condition runs", acc_o, 0);
    check("R5 zero flag set", {zero_o, neg_o}, 2'b10);
    issue(ACCADD, 9, 0, 0, 2'd3);
    check("R6 nonzero condition skipped", acc_o, 0);
  endtask

  task automatic t_ignore();
    logic [15:0] v;
    issue(SETA, 0, 12'h030); load_reg(1, 16'h0055); issue(ST8, 1);
    from_right_i = 16'h1111; issue(SHL);
    issue(ACCADD, 9, 0, 0, 0, 1'b1);
    check("R7 ignored add", acc_o, 0);
    check("R7 ignored add flags", {zero_o, neg_o}, 2'b10);
    from_right_i = 16'h2222; issue(SHL, 0, 0, 0, 0, 1'b1);
    check("R7 ignored shift", nbr_o, 16'h1111);
    issue(ST8, 9, 0, 0, 0, 1'b1);
    issue(LD8, 2); read_reg(2, v);
    check("R7 ignored store", v, 16'h0055);
    issue(SETA, 0, 12'h031); issue(ST16, 9, 0, 0, 0, 1'b1);
    check("R7 ignored odd store raises nothing", misalign_o, 0);
  endtask

  task automatic t_shift();
    from_right_i = 16'hA5A5; issue(SHL); check("R8 shift from right", nbr_o, 16'hA5A5);
    from_left_i = 16'h5A5A; issue(SHR); check("R8 shift from left", nbr_o, 16'h5A5A);
  endtask

  task automatic t_misalign();
    logic [15:0] v;
    load_reg(1, 16'hCAFE); issue(SETA, 0, 12'h050); issue(ST16, 1);
    load_reg(1, 16'h0000); issue(SETA, 0, 12'h051); issue(ST16, 1);
    check("R9 odd store flagged", misalign_o, 1);
    issue(0); check("R9 flag lasts one cycle", misalign_o, 0);
    issue(SETA, 0, 12'h050); issue(LD16, 2); read_reg(2, v);
    check("R9 odd store wrote nothing", v, 16'hCAFE);
    issue(SETA, 0, 12'h051); issue(LD16, 2);
    check("R9 odd load flagged", misalign_o, 1);
    read_reg(2, v); check("R9 odd load returns zero", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    @(negedge clk);
    t_regs();
    t_mem();
    t_mac();
    t_wrap();
    t_cond();
    t_ignore();
    t_shift();
    t_misalign();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule